// File: doc/BRIEF.md
# Size-Context Aliased Register File

This block holds eight 32-bit general registers behind one write port and one read port. Each port gets a 3-bit register number and a 2-bit size context. The context controls how the number is read. A doubleword context names a whole register. A word context names its low half-word. A byte context names one of eight byte lanes, which sit in the low half-words of the first four registers.

Reads are combinational. They return the selected field right-aligned and zero-extended to the full register width. A write updates only the selected field and keeps every other bit of the target register. A decode stage can use this one structure for all operand widths, so there is no need to keep separate narrow register copies.

Top module: `alias_rf`

## Requirements
- R1: In doubleword context (encoding 2'b10), register number n reads as all 32 bits of register n, and a write there replaces all 32 bits.
- R2: In word context (encoding 2'b01), register number n reads as bits 15:0 of register n, with bits 31:16 of the result zero.
- R3: A word-context write to register n replaces bits 15:0 from write data bits 15:0 and keeps bits 31:16.
- R4: In byte context (encoding 2'b00), numbers 0 to 3 select bits 7:0 of registers 0 to 3. A read returns them in bits 7:0 with the other bits zero. A write stores write data bits 7:0 there and keeps bits 31:8.
- R5: In byte context, numbers 4, 5, 6 and 7 select bits 15:8 of registers 0, 1, 2 and 3. A read returns that byte in bits 7:0 with the other bits zero. A write stores write data bits 7:0 into bits 15:8 and keeps the rest of the register. Registers 4 to 7 are not touched.
- R6: Context encoding 2'b11 makes a read return zero and makes a write have no effect on any register.
- R7: A read of the register being written in the same cycle returns the old contents. The new value is visible after the clock edge.
- R8: While the synchronous reset is high at a clock edge, every register is cleared to zero.
- R9: A write changes no register other than the one its number and context select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_num | input | 3 | Write register number |
| wr_ctx | input | 2 | Write size context |
| wr_data | input | 32 | Write data, right-aligned |
| rd_num | input | 3 | Read register number |
| rd_ctx | input | 2 | Read size context |
| rd_data | output | 32 | Selected field, zero-extended |

## Verification
The embedded assertions check several properties on every cycle:
- zero-extension of byte and word reads;
- a zero result for the reserved context;
- bits outside the write mask staying unchanged in the written register;
- every unaddressed register staying stable;
- all registers reading zero after a reset cycle.

Some behaviours can only be shown by the bench's scenarios, because the assertions do not tie the lane decode to the intended register:
- the lane aliasing, where byte numbers 4 to 7 reach bits 15:8 of registers 0 to 3;
- read-before-write timing within one cycle.

The bench shows the lane aliasing by writing through one context and reading back through another.

// File: rtl/alias_rf_pkg.sv
package alias_rf_pkg;

   typedef enum logic [1:0] {
      CTX_BYTE  = 2'b00,
      CTX_WORD  = 2'b01,
      CTX_DWORD = 2'b10,
      CTX_NONE  = 2'b11
   } ctx_e;

   typedef enum logic [2:0] {
      LANE_OFF,
      LANE_B0,
      LANE_B1,
      LANE_W,
      LANE_D
   } lane_e;

endpackage

// File: rtl/alias_lane_map.sv
module alias_lane_map
   import alias_rf_pkg::*;
#(
   parameter int NUM_REGS = 8,
   localparam int IDX_W = $clog2(NUM_REGS),
   localparam int HALF  = NUM_REGS / 2
) (
   input  logic [IDX_W-1:0] num,
   input  logic [1:0]       ctx,
   output logic [IDX_W-1:0] phys,
   output lane_e            lane
);

   always_comb begin
      phys = num;
      lane = LANE_OFF;
      unique case (ctx)
         CTX_DWORD: lane = LANE_D;
         CTX_WORD:  lane = LANE_W;
         CTX_BYTE: begin
            if (num >= IDX_W'(HALF)) begin
               phys = num - IDX_W'(HALF);
               lane = LANE_B1;
            end else begin
               lane = LANE_B0;
            end
         end
         default:   lane = LANE_OFF;
      endcase
   end

endmodule

// File: rtl/alias_rf_store.sv
module alias_rf_store #(
   parameter int NUM_REGS = 8,
   parameter int REG_W    = 32,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [REG_W-1:0] wmask,
   input  logic [REG_W-1:0] wbits,
   input  logic [IDX_W-1:0] ridx,
   output logic [REG_W-1:0] rword
);

   logic [NUM_REGS-1:0][REG_W-1:0] regs;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            regs[g] <= '0;
         else if (we && widx == IDX_W'(g))
            regs[g] <= (regs[g] & ~wmask) | (wbits & wmask);
      end

      // R3 R4 R5
      masked_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
         (we && widx == IDX_W'(g)) |=>
            (((regs[g] ^ $past(regs[g])) & ~$past(wmask)) == '0));

      // R9
      other_reg_stable_chk: assert property (@(posedge clk) disable iff (rst)
         !(we && widx == IDX_W'(g)) |=> $stable(regs[g]));

      // R8
      reset_clears_chk: assert property (@(posedge clk)
         rst |=> (regs[g] == '0));
   end

   assign rword = regs[ridx];

endmodule

// File: rtl/alias_rf.sv
module alias_rf
   import alias_rf_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int REG_W    = 32,
   localparam int IDX_W   = $clog2(NUM_REGS),
   localparam int BYTE_W  = 8,
   localparam int WORD_W  = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_num,
   input  logic [1:0]       wr_ctx,
   input  logic [REG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_num,
   input  logic [1:0]       rd_ctx,
   output logic [REG_W-1:0] rd_data
);

   initial begin
      assert (REG_W >= WORD_W)
         else $error("alias_rf: REG_W must hold a word");
      assert (NUM_REGS >= 2 && (1 << IDX_W) == NUM_REGS)
         else $error("alias_rf: NUM_REGS must be a power of two");
   end

   logic [IDX_W-1:0] w_phys, r_phys;
   lane_e            w_lane, r_lane;
   logic [REG_W-1:0] w_mask, w_bits, r_word;
   logic             w_go;

   alias_lane_map #(.NUM_REGS(NUM_REGS)) u_wmap (
      .num(wr_num), .ctx(wr_ctx), .phys(w_phys), .lane(w_lane));

   alias_lane_map #(.NUM_REGS(NUM_REGS)) u_rmap (
      .num(rd_num), .ctx(rd_ctx), .phys(r_phys), .lane(r_lane));

   always_comb begin
      w_mask = '0;
      w_bits = '0;
      unique case (w_lane)
         LANE_D: begin
            w_mask = '1;
            w_bits = wr_data;
         end
         LANE_W: begin
            w_mask = REG_W'({WORD_W{1'b1}});
            w_bits = REG_W'(wr_data[WORD_W-1:0]);
         end
         LANE_B0: begin
            w_mask = REG_W'({BYTE_W{1'b1}});
            w_bits = REG_W'(wr_data[BYTE_W-1:0]);
         end
         LANE_B1: begin
            w_mask = REG_W'({BYTE_W{1'b1}}) << BYTE_W;
            w_bits = REG_W'(wr_data[BYTE_W-1:0]) << BYTE_W;
         end
         default: ;
      endcase
   end

   assign w_go = wr_en && (w_lane != LANE_OFF);

   alias_rf_store #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_store (
      .clk(clk), .rst(rst), .we(w_go), .widx(w_phys),
      .wmask(w_mask), .wbits(w_bits), .ridx(r_phys), .rword(r_word));

   always_comb begin
      unique case (r_lane)
         LANE_D:  rd_data = r_word;
         LANE_W:  rd_data = REG_W'(r_word[WORD_W-1:0]);
         LANE_B0: rd_data = REG_W'(r_word[BYTE_W-1:0]);
         LANE_B1: rd_data = REG_W'(r_word[2*BYTE_W-1:BYTE_W]);
         default: rd_data = '0;
      endcase
   end

   // R6
   rd_none_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ctx == CTX_NONE) |-> (rd_data == '0));

   // R4
   rd_byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ctx == CTX_BYTE) |-> (rd_data[REG_W-1:BYTE_W] == '0));

   // R2
   rd_word_zext_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_ctx == CTX_WORD) |-> (rd_data[REG_W-1:WORD_W] == '0));

endmodule

// File: tb/sim_alias_rf.sv
module sim_alias_rf;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_num = '0;
   logic [1:0]  wr_ctx = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_num = '0;
   logic [1:0]  rd_ctx = 2'b10;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   alias_rf u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_num(wr_num), .wr_ctx(wr_ctx),
      .wr_data(wr_data), .rd_num(rd_num), .rd_ctx(rd_ctx), .rd_data(rd_data));

   localparam logic [1:0] B = 2'b00, W = 2'b01, D = 2'b10, N = 2'b11;
   localparam int NV = 18;
   // {we, wnum, wctx, wdata, rnum, rctx, expected read after the edge}
   localparam logic [74:0] VEC [NV] = '{
      {1'b1, 3'd0, D, 32'h11223344, 3'd0, D, 32'h11223344}, // R1
      {1'b1, 3'd1, D, 32'hA5A5F00F, 3'd1, W, 32'h0000F00F}, // R2
      {1'b1, 3'd0, W, 32'hFFFFBEEF, 3'd0, D, 32'h1122BEEF}, // R3
      {1'b1, 3'd1, B, 32'hDEADBE77, 3'd1, D, 32'hA5A5F077}, // R4
      {1'b1, 3'd5, B, 32'h000000C3, 3'd1, D, 32'hA5A5C377}, // R5
      {1'b0, 3'd0, D, 32'h00000000, 3'd5, B, 32'h000000C3}, // R5
      {1'b0, 3'd0, D, 32'h00000000, 3'd0, B, 32'h000000EF}, // R4
      {1'b0, 3'd0, D, 32'h00000000, 3'd4, B, 32'h000000BE}, // R5
      {1'b1, 3'd0, N, 32'h00000000, 3'd0, D, 32'h1122BEEF}, // R6
      {1'b0, 3'd0, D, 32'h00000000, 3'd0, N, 32'h00000000}, // R6
      {1'b1, 3'd7, B, 32'hFFFFFF5A, 3'd3, D, 32'h00005A00}, // R5
      {1'b1, 3'd3, B, 32'h0000003C, 3'd3, D, 32'h00005A3C}, // R4
      {1'b1, 3'd7, D, 32'hCAFEF00D, 3'd3, D, 32'h00005A3C}, // R9
      {1'b0, 3'd0, D, 32'h00000000, 3'd7, W, 32'h0000F00D}, // R2
      {1'b1, 3'd6, W, 32'h12345678, 3'd6, D, 32'h00005678}, // R3
      {1'b1, 3'd6, B, 32'h00000099, 3'd6, D, 32'h00005678}, // R5
      {1'b0, 3'd0, D, 32'h00000000, 3'd2, W, 32'h00009900}, // R5
      {1'b1, 3'd4, N, 32'hFFFFFFFF, 3'd0, D, 32'h1122BEEF}  // R6
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic drive(input logic we, input logic [2:0] wn, input logic [1:0] wc,
                        input logic [31:0] wd, input logic [2:0] rn, input logic [1:0] rc);
      wr_en = we; wr_num = wn; wr_ctx = wc; wr_data = wd; rd_num = rn; rd_ctx = rc;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R8: reset state
      for (int k = 0; k < 8; k++) begin
         drive(1'b0, 3'd0, D, '0, 3'(k), D);
         #1 check("R8 reset", rd_data, 32'h0);
      end

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i][74], VEC[i][73:71], VEC[i][70:69], VEC[i][68:37],
               VEC[i][36:34], VEC[i][33:32]);
         @(posedge clk);
         #1 check($sformatf("vector %0d", i), rd_data, VEC[i][31:0]);
      end

      // R7: same-cycle read returns old value
      @(negedge clk);
      drive(1'b1, 3'd5, D, 32'h55AA55AA, 3'd5, D);
      #2 check("R7 old value", rd_data, 32'h0);
      @(posedge clk);
      #1 check("R7 new value", rd_data, 32'h55AA55AA);

      // R1: full replace over existing contents
      @(negedge clk);
      drive(1'b1, 3'd0, D, 32'h0BADC0DE, 3'd0, D);
      @(posedge clk);
      #1 check("R1 dword replace", rd_data, 32'h0BADC0DE);

      // R8: reset mid-run clears everything
      @(negedge clk);
      drive(1'b0, 3'd0, D, '0, 3'd0, D);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < 8; k++) begin
         drive(1'b0, 3'd0, D, '0, 3'(k), D);
         #1 check("R8 cleared", rd_data, 32'h0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule